// File: doc/BRIEF.md
# Peripheral Clock Stop Sequencer

This block gates a bank of free-running 33 MHz single-ended peripheral clocks and one 100 MHz differential source-clock pair so that a single active-low stop request parks them in a fixed order and then releases them. The request is the OR of two sources: a pin (`stop_pin_n` low) and a control bit (`stop_reg` cleared). The request is sampled in the 33 MHz domain. Every stoppable single-ended output then parks low on its next falling edge. Only after that does the differential pair park, on a rising edge of its own clock. While it is parked, the true line is held high and the complement line is held low, or the pair is reported as tristated.

Each output has an enable bit and a free-run bit. Gating enables change only while the clock being gated sits at its parked level, so no output produces a shortened pulse, either when it stops or when it resumes. A two-bit drive code reports the state of the differential pair: RUN, parked-and-driven, reduced-drive park, or tristate. An analog driver stage downstream uses this code.

Top module: `pclk_stop_seq`

## Requirements
- R1: While `rst_n` is low, every `pci_clk_out` bit is 0, `src_clk_t` is 1, `src_clk_c` is 0, and `src_drive` is 2'b01 (parked, driven), given `src_oe`=1 and `src_stop_tri`=0.
- R2: A stop request is `stop_pin_n`=0 or `stop_reg`=0. The request is sampled on rising edges of `clk_pci` through SYNC_STAGES flops. A request applied during a low phase therefore lets a stoppable output make exactly SYNC_STAGES more rising edges before it parks.
- R3: Once the request is detected, each enabled output whose free-run bit is 0 goes low on the next falling edge of `clk_pci` and stays low while the request holds.
- R4: The differential pair parks only after the single-ended outputs have parked, on a rising edge of `clk_src`. While parked, `src_clk_t`=1, `src_clk_c`=0 and `src_drive`=2'b01.
- R5: If `src_stop_tri`=1, the parked pair reports `src_drive`=2'b11 (tristate) and `src_clk_c` stays 0.
- R6: An output whose free-run bit is 1 (`pci_free_run[i]` or `src_free_run`) keeps toggling through a stop. In that case the pair's code stays 2'b00 (RUN).
- R7: After the request is released, the first rising edge of a stopped single-ended output falls on the (SYNC_STAGES+1)-th rising edge of `clk_pci` after the release. The pair returns to code 2'b00. No output ever shows a high pulse shorter than its clock's half period.
- R8: An output whose enable bit is 0 is held low regardless of stop state. A disabled pair holds both lines at 0 and reports `src_drive`=2'b11.
- R9: Clearing `stop_reg` with the pin high gives the same stop sequence and edge counts as driving the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Free-running 33 MHz reference clock |
| clk_src | input | 1 | 100 MHz source clock for the differential pair |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Stop request pin, active low |
| stop_reg | input | 1 | Register stop bit; 0 requests stop (default 1) |
| pci_oe | input | N_PCI | Per-output enable for single-ended clocks |
| pci_free_run | input | N_PCI | Per-output free-run select (1 = ignore stop) |
| src_oe | input | 1 | Differential pair enable |
| src_free_run | input | 1 | Differential pair free-run select |
| src_stop_tri | input | 1 | 1 = tristate the pair while stopped |
| pci_clk_out | output | N_PCI | Gated single-ended clocks |
| src_clk_t | output | 1 | Gated true side of the pair |
| src_clk_c | output | 1 | Gated complement side of the pair |
| src_drive | output | 2 | Pair drive code: 00 RUN, 01 park driven, 10 park reduced, 11 tristate |

## Verification
The bench builds the block with N_PCI=4 and SYNC_STAGES=2. With four outputs, one bank can hold an output that stops, one that is disabled, one that runs free, and a second stoppable output, so every per-output mode is exercised in the same stop event. With two sampling stages, the latency becomes an exact count: two more edges before the park and a first pulse on the third edge after release. The two clocks run in a fixed 3:1 ratio with offset phases. This makes the park order, pair after bank, visible as edge times.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    DRV_RUN      = 2'b00,
    DRV_PARK_6X  = 2'b01,
    DRV_PARK_2X  = 2'b10,
    DRV_TRISTATE = 2'b11
  } pair_drive_e;

  // Stop is wanted when the pin is low or the register bit is cleared.
  function automatic logic stop_wanted(input logic pin_n, input logic reg_bit);
    return (!pin_n) || (!reg_bit);
  endfunction

  // Gate enable of one single-ended output.
  function automatic logic out_enable(input logic oe, input logic free_run,
                                      input logic stop);
    return oe && (free_run || !stop);
  endfunction

  // Drive code of the differential pair.
  function automatic pair_drive_e pair_code(input logic oe, input logic run,
                                            input logic tri_park);
    if (!oe)          return DRV_TRISTATE;
    else if (run)     return DRV_RUN;
    else if (tri_park) return DRV_TRISTATE;
    else              return DRV_PARK_6X;
  endfunction
endpackage

// File: rtl/pcs_stop_sampler.sv
module pcs_stop_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_pci,
  input  logic rst_n,
  input  logic stop_pin_n,
  input  logic stop_reg,
  output logic stop_seen,
  output logic se_parked
);
  import pcs_pkg::*;

  logic [SYNC_STAGES-1:0] chain;
  logic                   req;

  assign req = stop_wanted(stop_pin_n, stop_reg);

  always_ff @(posedge clk_pci or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= req;
      for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign stop_seen = chain[SYNC_STAGES-1];

  // Marks the falling edge at which the bank took the stop into its enables.
  always_ff @(negedge clk_pci or negedge rst_n) begin
    if (!rst_n) se_parked <= 1'b0;
    else        se_parked <= stop_seen;
  end
endmodule

// File: rtl/pcs_se_gate.sv
module pcs_se_gate #(
  parameter int N_PCI = 7
) (
  input  logic             clk_pci,
  input  logic             rst_n,
  input  logic             stop_seen,
  input  logic [N_PCI-1:0] pci_oe,
  input  logic [N_PCI-1:0] pci_free_run,
  output logic [N_PCI-1:0] pci_clk_out
);
  import pcs_pkg::*;

  logic [N_PCI-1:0] en_q;

  for (genvar i = 0; i < N_PCI; i++) begin : g_out
    // Enable moves on the falling edge, while the clock is already low.
    always_ff @(negedge clk_pci or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b0;
      else        en_q[i] <= out_enable(pci_oe[i], pci_free_run[i], stop_seen);
    end
    assign pci_clk_out[i] = clk_pci & en_q[i];
  end
endmodule

// File: rtl/pcs_diff_gate.sv
module pcs_diff_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_src,
  input  logic       rst_n,
  input  logic       se_parked,
  input  logic       src_oe,
  input  logic       src_free_run,
  input  logic       src_stop_tri,
  output logic       src_clk_t,
  output logic       src_clk_c,
  output logic [1:0] src_drive,
  output logic       pair_run
);
  import pcs_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   park_req;
  pair_drive_e            code;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= se_parked;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign park_req = sync_q[SYNC_STAGES-1] & ~src_free_run;

  // Run flag moves on the rising edge: true is high and complement low there.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) pair_run <= 1'b0;
    else        pair_run <= ~park_req;
  end

  assign code      = pair_code(src_oe, pair_run, src_stop_tri);
  assign src_drive = code;
  assign src_clk_t = src_oe & (pair_run ? clk_src : 1'b1);
  assign src_clk_c = src_oe & pair_run & ~clk_src;
endmodule

// File: rtl/pclk_stop_seq.sv
module pclk_stop_seq #(
  parameter int N_PCI       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_pci,
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_pin_n,
  input  logic             stop_reg,
  input  logic [N_PCI-1:0] pci_oe,
  input  logic [N_PCI-1:0] pci_free_run,
  input  logic             src_oe,
  input  logic             src_free_run,
  input  logic             src_stop_tri,
  output logic [N_PCI-1:0] pci_clk_out,
  output logic             src_clk_t,
  output logic             src_clk_c,
  output logic [1:0]       src_drive
);
  // Named internal events, observed by the checker.
  logic stop_seen;
  logic se_parked;
  logic pair_run;

  pcs_stop_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_pci   (clk_pci),
    .rst_n     (rst_n),
    .stop_pin_n(stop_pin_n),
    .stop_reg  (stop_reg),
    .stop_seen (stop_seen),
    .se_parked (se_parked)
  );

  pcs_se_gate #(.N_PCI(N_PCI)) u_se (
    .clk_pci     (clk_pci),
    .rst_n       (rst_n),
    .stop_seen   (stop_seen),
    .pci_oe      (pci_oe),
    .pci_free_run(pci_free_run),
    .pci_clk_out (pci_clk_out)
  );

  pcs_diff_gate #(.SYNC_STAGES(SYNC_STAGES)) u_diff (
    .clk_src     (clk_src),
    .rst_n       (rst_n),
    .se_parked   (se_parked),
    .src_oe      (src_oe),
    .src_free_run(src_free_run),
    .src_stop_tri(src_stop_tri),
    .src_clk_t   (src_clk_t),
    .src_clk_c   (src_clk_c),
    .src_drive   (src_drive),
    .pair_run    (pair_run)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int N_PCI = 7
) (
  input logic             clk_pci,
  input logic             clk_src,
  input logic             rst_n,
  input logic [N_PCI-1:0] pci_oe,
  input logic [N_PCI-1:0] pci_free_run,
  input logic             src_oe,
  input logic [N_PCI-1:0] pci_clk_out,
  input logic             src_clk_t,
  input logic             src_clk_c,
  input logic [1:0]       src_drive,
  input logic             se_parked,
  input logic             pair_run
);
  // R3: once the bank is parked, stoppable outputs are low during the high phase.
  a_r3_bank_parked_low: assert property (@(negedge clk_pci) disable iff (!rst_n)
    se_parked |-> ((pci_clk_out & ~pci_free_run) == '0));

  // R6: enabled free-running outputs are high during every high phase.
  a_r6_free_run_toggles: assert property (@(negedge clk_pci) disable iff (!rst_n)
    $past(rst_n) |-> ((pci_oe & pci_free_run & ~pci_clk_out) == '0));

  // R4: the pair stops running only after the bank has parked.
  a_r4_pair_after_bank: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(pair_run) |-> se_parked);

  // R4: a driven park holds true high and complement low.
  a_r4_park_levels: assert property (@(posedge clk_src) disable iff (!rst_n)
    (src_drive == 2'b01) |-> (src_clk_t && !src_clk_c));

  // R8: a disabled pair is tristated with both lines low.
  a_r8_pair_disabled: assert property (@(posedge clk_src) disable iff (!rst_n)
    !src_oe |-> ((src_drive == 2'b11) && !src_clk_t && !src_clk_c));
endmodule

bind pclk_stop_seq pcs_checker #(.N_PCI(N_PCI)) u_chk (
  .clk_pci     (clk_pci),
  .clk_src     (clk_src),
  .rst_n       (rst_n),
  .pci_oe      (pci_oe),
  .pci_free_run(pci_free_run),
  .src_oe      (src_oe),
  .pci_clk_out (pci_clk_out),
  .src_clk_t   (src_clk_t),
  .src_clk_c   (src_clk_c),
  .src_drive   (src_drive),
  .se_parked   (se_parked),
  .pair_run    (pair_run)
);

// File: tb/pclk_stop_seq_tb.sv
`timescale 1ns/1ps
module pclk_stop_seq_tb;
  localparam int  N    = 4;
  localparam int  SYNC = 2;
  localparam real TPCI = 24.0;
  localparam real HALF = 12.0;
  localparam real FIRST_RISE = 9.0 + TPCI * SYNC;

  logic clk_pci = 1'b0, clk_src = 1'b0, rst_n = 1'b0;
  logic stop_pin_n = 1'b1, stop_reg = 1'b1;
  logic [N-1:0] pci_oe = 4'b1101, pci_free_run = 4'b1000;
  logic src_oe = 1'b1, src_free_run = 1'b0, src_stop_tri = 1'b0;
  logic [N-1:0] pci_clk_out;
  logic src_clk_t, src_clk_c;
  logic [1:0] src_drive;

  int checks = 0, errors = 0;

  always #4 clk_src = ~clk_src;           // 125 MHz
  initial begin #2; forever #12 clk_pci = ~clk_pci; end

  pclk_stop_seq #(.N_PCI(N), .SYNC_STAGES(SYNC)) u_dut (
    .clk_pci(clk_pci), .clk_src(clk_src), .rst_n(rst_n),
    .stop_pin_n(stop_pin_n), .stop_reg(stop_reg),
    .pci_oe(pci_oe), .pci_free_run(pci_free_run),
    .src_oe(src_oe), .src_free_run(src_free_run), .src_stop_tri(src_stop_tri),
    .pci_clk_out(pci_clk_out), .src_clk_t(src_clk_t), .src_clk_c(src_clk_c),
    .src_drive(src_drive));

  // Edge monitors
  int      rise_cnt [N];
  realtime rise_t [N], fall_t [N];
  logic [N-1:0] prev_out = '0;
  realtime last_se_fall = 0, last_t_edge = 0, first_rise = 0;
  realtime t_rise = 0, t_fall = 0;
  int      t_rise_cnt = 0, runt = 0;
  bit      mon_en = 1'b1, arm = 1'b0;
  logic    prev_t = 1'b1;

  initial for (int i = 0; i < N; i++) begin rise_cnt[i] = 0; rise_t[i] = 0; fall_t[i] = 0; end

  always @(pci_clk_out) begin
    for (int i = 0; i < N; i++) begin
      if (pci_clk_out[i] !== prev_out[i]) begin
        if (pci_clk_out[i] === 1'b1) begin
          if (mon_en && ($realtime - fall_t[i]) < HALF - 0.01) runt++;
          rise_cnt[i]++;
          rise_t[i] = $realtime;
          if (arm && i == 0) begin first_rise = $realtime; arm = 1'b0; end
        end else begin
          if (mon_en && (($realtime - rise_t[i]) < HALF - 0.01 ||
                         ($realtime - rise_t[i]) > HALF + 0.01)) runt++;
          fall_t[i] = $realtime;
          if (i == 0 || i == 2) last_se_fall = $realtime;
        end
      end
    end
    prev_out = pci_clk_out;
  end

  always @(src_clk_t) begin
    if (src_clk_t !== prev_t) begin
      if (src_clk_t === 1'b1) begin
        if (mon_en && ($realtime - t_fall) < 3.99) runt++;
        t_rise = $realtime; t_rise_cnt++;
      end else begin
        if (mon_en && ($realtime - t_rise) < 3.99) runt++;
        t_fall = $realtime;
      end
      last_t_edge = $realtime;
    end
    prev_t = src_clk_t;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic align();
    @(negedge clk_pci); #3;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N; i++) rise_cnt[i] = 0;
    t_rise_cnt = 0;
  endtask

  task automatic t_reset();
    #50;
    check(pci_clk_out == '0, "R1 bank low in reset", int'(pci_clk_out), 0);
    check(src_drive == 2'b01, "R1 pair code in reset", int'(src_drive), 1);
    check(src_clk_t && !src_clk_c, "R1 pair levels in reset",
          int'({src_clk_t, src_clk_c}), 2);
  endtask

  task automatic t_run();
    align(); clear_counts();
    #(TPCI * 4);
    check(rise_cnt[0] == 4, "R3 bit0 runs", rise_cnt[0], 4);
    check(rise_cnt[2] == 4, "R3 bit2 runs", rise_cnt[2], 4);
    check(rise_cnt[3] == 4, "R6 free bit runs", rise_cnt[3], 4);
    check(rise_cnt[1] == 0, "R8 disabled bit low", rise_cnt[1], 0);
    check(src_drive == 2'b00, "R7 pair running", int'(src_drive), 0);
  endtask

  task automatic t_stop(input bit use_reg, input bit tri_mode);
    string tag;
    tag = use_reg ? "R9" : "R2";
    src_stop_tri = tri_mode;
    align(); clear_counts();
    if (use_reg) stop_reg = 1'b0; else stop_pin_n = 1'b0;
    #(TPCI * 8);
    check(rise_cnt[0] == SYNC, {tag, " edges before park bit0"}, rise_cnt[0], SYNC);
    check(rise_cnt[2] == SYNC, {tag, " edges before park bit2"}, rise_cnt[2], SYNC);
    check(rise_cnt[3] == 8, "R6 free bit through stop", rise_cnt[3], 8);
    check(rise_cnt[1] == 0, "R8 disabled bit through stop", rise_cnt[1], 0);
    check((pci_clk_out & 4'b0101) == '0, "R3 stoppable parked low",
          int'(pci_clk_out), 0);
    if (tri_mode) begin
      check(src_drive == 2'b11, "R5 tristate park code", int'(src_drive), 3);
      check(!src_clk_c, "R5 complement low", int'(src_clk_c), 0);
    end else begin
      check(src_drive == 2'b01, "R4 driven park code", int'(src_drive), 1);
      check(src_clk_t && !src_clk_c, "R4 park levels",
            int'({src_clk_t, src_clk_c}), 2);
    end
    check(last_t_edge > last_se_fall, "R4 pair parks after bank",
          $rtoi(last_t_edge), $rtoi(last_se_fall));
    // release
    align(); arm = 1'b1;
    begin
      realtime t0;
      t0 = $realtime;
      if (use_reg) stop_reg = 1'b1; else stop_pin_n = 1'b1;
      #(TPCI * 8);
      check((first_rise - t0) > FIRST_RISE - 0.01 && (first_rise - t0) < FIRST_RISE + 0.01,
            "R7 first pulse after release", $rtoi(first_rise - t0), $rtoi(FIRST_RISE));
    end
    check(src_drive == 2'b00, "R7 pair resumes", int'(src_drive), 0);
    check(runt == 0, "R7 no short pulses", runt, 0);
    src_stop_tri = 1'b0;
  endtask

  task automatic t_src_free();
    src_free_run = 1'b1;
    align(); clear_counts();
    stop_pin_n = 1'b0;
    #(TPCI * 8);
    check(src_drive == 2'b00, "R6 free pair code", int'(src_drive), 0);
    check(t_rise_cnt == 24, "R6 free pair toggles", t_rise_cnt, 24);
    stop_pin_n = 1'b1;
    #(TPCI * 8);
    src_free_run = 1'b0;
    check(runt == 0, "R6 no short pulses", runt, 0);
  endtask

  task automatic t_src_off();
    mon_en = 1'b0;
    align();
    src_oe = 1'b0;
    #1; clear_counts();
    #(TPCI * 4);
    check(src_drive == 2'b11, "R8 disabled pair code", int'(src_drive), 3);
    check(!src_clk_t && !src_clk_c, "R8 disabled pair lines",
          int'({src_clk_t, src_clk_c}), 0);
    check(t_rise_cnt == 0, "R8 disabled pair quiet", t_rise_cnt, 0);
  endtask

  initial begin
    t_reset();
    #51 rst_n = 1'b1;
    #(TPCI * 10);
    t_run();
    t_stop(1'b0, 1'b0);
    t_stop(1'b1, 1'b0);
    t_stop(1'b0, 1'b1);
    t_src_free();
    t_src_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule